// File: doc/BRIEF.md
# Sector Code Comparator and Single-Bit Repair

This block compares two 24-bit check codes that belong to one 512-byte sector: the code kept in the flash spare area and the code just computed over the data that was read. It reorders both codes into a common 24-bit form and XORs them into a syndrome. It then counts the set bits of the syndrome and reports one of three outcomes: the data is clean, one data bit is wrong and can be repaired, or the damage cannot be repaired. A sector that was never programmed has an all-ones stored code and an all-zero computed code. That pair is reported as clean.

For a repairable error the block reports the byte offset and the bit index to flip. When the `APPLY_FIX` parameter is set, it also repairs the byte in the sector buffer. It reads the byte once through a buffer port with one-cycle read latency. On the next cycle it writes the byte back with that single bit inverted. A caller starts one sector with a one-cycle `start_i` pulse and waits for the one-cycle `done_o` pulse. The results stay on the outputs until the next accepted start.

Top module: `sector_ecc_fixer`

## Requirements
- R1: When the stored and computed codes are identical, status is clean (0), the byte offset and bit index are 0, and no buffer write occurs.
- R2: A code arrives as three bytes: byte 0 on bits [7:0], byte 1 on [15:8] and byte 2 on [23:16]. The syndrome takes bits 0..5 from byte 2 bits 2..7, bits 6..13 from byte 0, bits 14..21 from byte 1, and bits 22..23 from byte 2 bits 0..1, XORed between the two codes.
- R3: A syndrome with exactly 12 set bits gives status repaired (1). The byte offset is syndrome bits 23,21,19,17,15,13,11,9,7 (most to least significant) and the bit index is syndrome bits 5,3,1.
- R4: A syndrome with exactly 1 or exactly 11 set bits gives status uncorrectable (2).
- R5: A stored code of 0xFFFFFF with a computed code of 0x000000 gives status clean. Every other nonzero syndrome whose count is not 12 gives status uncorrectable.
- R6: On a repair, the buffer read at the offset comes one cycle after the start is taken. The write to the same address follows one cycle later, with the read byte XORed with a one-hot mask at the bit index, so that exactly that bit changes.
- R7: For outcomes other than repaired, the block makes no buffer read or write.
- R8: A start is taken only while idle. A start while busy has no effect. `done_o` is a single-cycle pulse two cycles after the start edge (three for a repair), and the results hold until the next start.
- R9: With `APPLY_FIX` = 0 the block reports the same status, offset and bit. It never reads or writes the buffer, and `done_o` always comes two cycles after the start.
- R10: After reset, `done_o`, both buffer enables, the status, the offset and the bit index are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin evaluating one sector |
| stored_code_i | input | 24 | Code read from the spare area |
| calc_code_i | input | 24 | Code computed over the read data |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 clean, 1 repaired, 2 uncorrectable |
| byte_off_o | output | 9 | Offset of the erroneous byte |
| bit_idx_o | output | 3 | Index of the erroneous bit in the byte |
| buf_rd_en_o | output | 1 | Sector buffer read request |
| buf_wr_en_o | output | 1 | Sector buffer write request |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_wdata_o | output | 8 | Repaired byte to write |
| buf_rdata_i | input | 8 | Byte read from the buffer, one cycle after the read request |

## Verification
The bench builds two copies side by side on the same stimulus. One uses `APPLY_FIX` = 1, with a behavioural 512-byte buffer and a golden copy of that buffer. The other uses `APPLY_FIX` = 0. Comparing the pair shows that classification does not depend on the repair variant, while timing and buffer traffic do. Both copies use the default 512-byte sector and 8-bit data. This makes the extreme offsets 0 and 511 and bit indices 0 and 7 reachable, as well as the syndrome counts 1, 2, 11, 12, 13, 23 and 24 and the erased-sector pairing.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
   localparam int SFX_CODE_W = 24;
   localparam int SFX_OFF_W  = 9;
   localparam int SFX_BIT_W  = 3;

   typedef enum logic [1:0] {
      SFX_OK    = 2'd0,
      SFX_FIXED = 2'd1,
      SFX_BAD   = 2'd2
   } sfx_status_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_EVAL  = 2'd1,
      S_WRITE = 2'd2,
      S_FIN   = 2'd3
   } sfx_state_e;
endpackage

// File: rtl/sfx_syndrome.sv
module sfx_syndrome #(
   parameter int CODE_W = 24,
   parameter int ROT    = 6,
   parameter int CNT_W  = $clog2(CODE_W + 1)
) (
   input  logic [CODE_W-1:0] stored_i,
   input  logic [CODE_W-1:0] calc_i,
   output logic [CODE_W-1:0] syn_o,
   output logic [CNT_W-1:0]  ones_o,
   output logic              erased_o
);
   // reorder both codes into the common form and XOR them
   for (genvar i = 0; i < CODE_W; i++) begin : g_map
      localparam int SRC = (i < ROT) ? i + CODE_W - ROT : i - ROT;
      assign syn_o[i] = stored_i[SRC] ^ calc_i[SRC];
   end

   always_comb begin
      ones_o = '0;
      for (int i = 0; i < CODE_W; i++)
         ones_o = ones_o + CNT_W'(syn_o[i]);
   end

   assign erased_o = (&stored_i) && !(|calc_i);
endmodule

// File: rtl/sfx_classify.sv
module sfx_classify
   import sfx_pkg::*;
#(
   parameter int CODE_W   = 24,
   parameter int FIX_ONES = 12,
   parameter int OFF_W    = 9,
   parameter int BIT_W    = 3,
   parameter int CNT_W    = $clog2(CODE_W + 1)
) (
   input  logic [CODE_W-1:0] syn_i,
   input  logic [CNT_W-1:0]  ones_i,
   input  logic              erased_i,
   output sfx_status_e       status_o,
   output logic [OFF_W-1:0]  off_o,
   output logic [BIT_W-1:0]  bit_o
);
   localparam int HALF = CODE_W / 2;
   logic [HALF-1:0] odd_bits;

   // odd syndrome positions carry the error location
   for (genvar k = 0; k < HALF; k++) begin : g_odd
      assign odd_bits[k] = syn_i[2*k+1];
   end

   always_comb begin
      status_o = SFX_BAD;
      if (ones_i == '0)                       status_o = SFX_OK;
      else if (ones_i == CNT_W'(FIX_ONES))    status_o = SFX_FIXED;
      else if (erased_i)                      status_o = SFX_OK;
   end

   assign bit_o = (status_o == SFX_FIXED) ? odd_bits[BIT_W-1:0] : '0;
   assign off_o = (status_o == SFX_FIXED) ? odd_bits[BIT_W +: OFF_W] : '0;
endmodule

// File: rtl/sfx_seq.sv
module sfx_seq
   import sfx_pkg::*;
#(
   parameter int APPLY_FIX = 1,
   parameter int OFF_W     = 9,
   parameter int BIT_W     = 3,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              accept_o,
   input  sfx_status_e       cls_status_i,
   input  logic [OFF_W-1:0]  cls_off_i,
   input  logic [BIT_W-1:0]  cls_bit_i,
   output logic              done_o,
   output sfx_status_e       status_o,
   output logic [OFF_W-1:0]  off_o,
   output logic [BIT_W-1:0]  bit_o,
   output logic              buf_rd_en_o,
   output logic              buf_wr_en_o,
   output logic [OFF_W-1:0]  buf_addr_o,
   output logic [DATA_W-1:0] buf_wdata_o,
   input  logic [DATA_W-1:0] buf_rdata_i
);
   localparam bit FIX_ON = (APPLY_FIX != 0);

   sfx_state_e st, nxt;
   logic       go_fix;

   assign accept_o = start_i && (st == S_IDLE);
   assign go_fix   = FIX_ON && (cls_status_i == SFX_FIXED);
   assign done_o   = (st == S_FIN);

   always_comb begin
      nxt = st;
      case (st)
         S_IDLE:  if (start_i) nxt = S_EVAL;
         S_EVAL:  nxt = go_fix ? S_WRITE : S_FIN;
         S_WRITE: nxt = S_FIN;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         status_o <= SFX_OK;
         off_o    <= '0;
         bit_o    <= '0;
      end else begin
         st <= nxt;
         if (st == S_EVAL) begin
            status_o <= cls_status_i;
            off_o    <= cls_off_i;
            bit_o    <= cls_bit_i;
         end
      end
   end

   if (FIX_ON) begin : g_rmw
      assign buf_rd_en_o = (st == S_EVAL) && (cls_status_i == SFX_FIXED);
      assign buf_wr_en_o = (st == S_WRITE);
      assign buf_addr_o  = (st == S_WRITE) ? off_o : cls_off_i;
      assign buf_wdata_o = buf_rdata_i ^ (DATA_W'(1) << bit_o);
   end else begin : g_report
      assign buf_rd_en_o = 1'b0;
      assign buf_wr_en_o = 1'b0;
      assign buf_addr_o  = '0;
      assign buf_wdata_o = '0;
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R6
   rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en_o |-> $past(buf_rd_en_o));
   // R6
   rmw_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en_o |-> (buf_addr_o == $past(buf_addr_o)));
   // R6
   one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en_o |-> ($countones(buf_wdata_o ^ buf_rdata_i) == 1));
   // R7
   no_stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o != SFX_FIXED) |-> !$past(buf_wr_en_o));
endmodule

// File: rtl/sector_ecc_fixer.sv
module sector_ecc_fixer
   import sfx_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int DATA_W       = 8,
   parameter int APPLY_FIX    = 1,
   localparam int OFF_W = $clog2(SECTOR_BYTES),
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [23:0]       stored_code_i,
   input  logic [23:0]       calc_code_i,
   output logic              done_o,
   output logic [1:0]        status_o,
   output logic [OFF_W-1:0]  byte_off_o,
   output logic [BIT_W-1:0]  bit_idx_o,
   output logic              buf_rd_en_o,
   output logic              buf_wr_en_o,
   output logic [OFF_W-1:0]  buf_addr_o,
   output logic [DATA_W-1:0] buf_wdata_o,
   input  logic [DATA_W-1:0] buf_rdata_i
);
   localparam int CNT_W = $clog2(SFX_CODE_W + 1);

   if (OFF_W != SFX_OFF_W) begin : g_bad_sector
      $error("SECTOR_BYTES must give a 9-bit byte offset");
   end
   if (BIT_W != SFX_BIT_W || DATA_W != (1 << BIT_W)) begin : g_bad_data
      $error("DATA_W must be 8");
   end

   logic [SFX_CODE_W-1:0] st_q, ca_q, syn;
   logic [CNT_W-1:0]      ones;
   logic                  erased, accept;
   sfx_status_e           cls_status, res_status;
   logic [OFF_W-1:0]      cls_off;
   logic [BIT_W-1:0]      cls_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
         ca_q <= '0;
      end else if (accept) begin
         st_q <= stored_code_i;
         ca_q <= calc_code_i;
      end
   end

   sfx_syndrome #(.CODE_W(SFX_CODE_W), .ROT(6), .CNT_W(CNT_W)) u_syn (
      .stored_i(st_q), .calc_i(ca_q), .syn_o(syn), .ones_o(ones), .erased_o(erased));

   sfx_classify #(.CODE_W(SFX_CODE_W), .FIX_ONES(SFX_CODE_W/2), .OFF_W(OFF_W),
                  .BIT_W(BIT_W), .CNT_W(CNT_W)) u_cls (
      .syn_i(syn), .ones_i(ones), .erased_i(erased),
      .status_o(cls_status), .off_o(cls_off), .bit_o(cls_bit));

   sfx_seq #(.APPLY_FIX(APPLY_FIX), .OFF_W(OFF_W), .BIT_W(BIT_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_o(accept),
      .cls_status_i(cls_status), .cls_off_i(cls_off), .cls_bit_i(cls_bit),
      .done_o(done_o), .status_o(res_status), .off_o(byte_off_o), .bit_o(bit_idx_o),
      .buf_rd_en_o(buf_rd_en_o), .buf_wr_en_o(buf_wr_en_o), .buf_addr_o(buf_addr_o),
      .buf_wdata_o(buf_wdata_o), .buf_rdata_i(buf_rdata_i));

   assign status_o = res_status;
endmodule

// File: tb/tb_sector_ecc_fixer.sv
module tb_sector_ecc_fixer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] stored = '0, calc = '0;

   logic       done, rd_en, wr_en;
   logic [1:0] status;
   logic [8:0] off, addr;
   logic [2:0] bidx;
   logic [7:0] wdata, rdata;

   logic       done_ro, rd_ro, wr_ro;
   logic [1:0] status_ro;
   logic [8:0] off_ro, addr_ro;
   logic [2:0] bidx_ro;
   logic [7:0] wdata_ro;

   int compared = 0, mismatched = 0, cyc = 0;
   int exp_rd = -1, exp_wr = -1, exp_done = -1, exp_done_ro = -1;
   bit run_chk = 0, finished = 0;
   logic [7:0] mem  [512];
   logic [7:0] gold [512];

   always #2.5 clk = ~clk;

   sector_ecc_fixer #(.APPLY_FIX(1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stored_code_i(stored), .calc_code_i(calc),
      .done_o(done), .status_o(status), .byte_off_o(off), .bit_idx_o(bidx),
      .buf_rd_en_o(rd_en), .buf_wr_en_o(wr_en), .buf_addr_o(addr),
      .buf_wdata_o(wdata), .buf_rdata_i(rdata));

   sector_ecc_fixer #(.APPLY_FIX(0)) dut_ro (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stored_code_i(stored), .calc_code_i(calc),
      .done_o(done_ro), .status_o(status_ro), .byte_off_o(off_ro), .bit_idx_o(bidx_ro),
      .buf_rd_en_o(rd_ro), .buf_wr_en_o(wr_ro), .buf_addr_o(addr_ro),
      .buf_wdata_o(wdata_ro), .buf_rdata_i(8'h00));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd_en) rdata <= mem[addr];
      if (wr_en) mem[addr] <= wdata;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // per-clock comparison against the reference timing model
   always @(negedge clk) begin
      if (run_chk && !finished) begin
         check(done == (cyc == exp_done), "R8 done timing", done, cyc == exp_done);
         check(rd_en == (cyc == exp_rd), "R6/R7 read timing", rd_en, cyc == exp_rd);
         check(wr_en == (cyc == exp_wr), "R6/R7 write timing", wr_en, cyc == exp_wr);
         check(done_ro == (cyc == exp_done_ro), "R9 done timing", done_ro, cyc == exp_done_ro);
         check(!rd_ro && !wr_ro, "R9 buffer quiet", {rd_ro, wr_ro}, 0);
      end
   end

   function automatic int src_of(input int i);
      return (i < 6) ? i + 18 : i - 6;
   endfunction

   function automatic logic [23:0] to_form(input logic [23:0] c);
      logic [23:0] r;
      for (int i = 0; i < 24; i++) r[i] = c[src_of(i)];
      return r;
   endfunction

   function automatic logic [23:0] from_form(input logic [23:0] s);
      logic [23:0] c;
      for (int i = 0; i < 24; i++) c[src_of(i)] = s[i];
      return c;
   endfunction

   function automatic logic [23:0] loc_syn(input int boff, input int bbit);
      logic [23:0] s;
      logic [11:0] loc;
      loc = {boff[8:0], bbit[2:0]};
      for (int k = 0; k < 12; k++) begin
         s[2*k+1] = loc[k];
         s[2*k]   = ~loc[k];
      end
      return s;
   endfunction

   task automatic run_op(input logic [23:0] st, input logic [23:0] ca,
                         input bit poke_busy, input string tag);
      logic [23:0] syn;
      int ones, e_status, e_off, e_bit, n;
      logic [11:0] loc;
      syn = to_form(st) ^ to_form(ca);
      ones = 0;
      for (int i = 0; i < 24; i++) ones += syn[i];
      e_off = 0; e_bit = 0;
      if (ones == 0) e_status = 0;
      else if (ones == 12) e_status = 1;
      else if (st == 24'hFFFFFF && ca == 24'h000000) e_status = 0;
      else e_status = 2;
      if (e_status == 1) begin
         for (int k = 0; k < 12; k++) loc[k] = syn[2*k+1];
         e_bit = loc[2:0];
         e_off = loc[11:3];
         gold[e_off] = gold[e_off] ^ (8'd1 << e_bit);
      end
      @(negedge clk);
      start = 1'b1; stored = st; calc = ca;
      n = cyc;
      exp_rd      = (e_status == 1) ? n + 1 : -1;
      exp_wr      = (e_status == 1) ? n + 2 : -1;
      exp_done    = (e_status == 1) ? n + 3 : n + 2;
      exp_done_ro = n + 2;
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         start = 1'b1; stored = ~st; calc = st;
         @(negedge clk);
         start = 1'b0;
      end
      while (cyc < exp_done) @(negedge clk);
      check(status == 2'(e_status), {tag, " status"}, status, e_status);
      check(off == 9'(e_off), {tag, " offset"}, off, e_off);
      check(bidx == 3'(e_bit), {tag, " bit"}, bidx, e_bit);
      check(status_ro == 2'(e_status) && off_ro == 9'(e_off) && bidx_ro == 3'(e_bit),
            "R9 report-only result", {status_ro, off_ro, bidx_ro}, {e_status[1:0], e_off[8:0], e_bit[2:0]});
      @(negedge clk);
      @(negedge clk);
      begin
         int bad = 0;
         for (int a = 0; a < 512; a++) if (mem[a] !== gold[a]) bad++;
         check(bad == 0, (e_status == 1) ? "R6 buffer contents" : "R7 buffer untouched", bad, 0);
      end
      check(status == 2'(e_status) && off == 9'(e_off), "R8 result hold",
            {status, off}, {e_status[1:0], e_off[8:0]});
   endtask

   task automatic fix_op(input logic [23:0] st, input int boff, input int bbit, input string tag);
      run_op(st, from_form(to_form(st) ^ loc_syn(boff, bbit)), 0, tag);
   endtask

   task automatic syn_op(input logic [23:0] st, input logic [23:0] s, input string tag);
      run_op(st, from_form(to_form(st) ^ s), 0, tag);
   endtask

   always @(posedge clk) begin
      if (!finished && cyc > 50000) begin
         finished = 1;
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual %0d expected 0", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 512; a++) begin
         mem[a]  = 8'((a * 37 + 5) ^ (a >> 3));
         gold[a] = 8'((a * 37 + 5) ^ (a >> 3));
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(!done && !rd_en && !wr_en && status == 0 && off == 0 && bidx == 0,
            "R10 reset outputs", {done, rd_en, wr_en, status, off, bidx}, 0);
      run_chk = 1;

      run_op(24'h123456, 24'h123456, 0, "R1 identical");
      run_op(24'h000000, 24'h000000, 0, "R1 identical zero");
      run_op(24'hFFFFFF, 24'hFFFFFF, 0, "R1 identical ones");

      fix_op(24'hA5C3E1, 0, 0, "R2/R3 fix first");
      fix_op(24'h3C5A96, 511, 7, "R2/R3 fix last");
      fix_op(24'h000000, 170, 5, "R2/R3 fix mid");
      fix_op(24'hFFFFFF, 341, 2, "R2/R3 fix mid2");
      fix_op(24'h777777, 256, 4, "R2/R3 fix high");
      fix_op(24'h0F0F0F, 256, 4, "R2/R3 fix repeat");
      syn_op(24'h13579B, 24'h000FFF, "R3 twelve low bits");

      syn_op(24'h2468AC, 24'h000001, "R4 one bit low");
      syn_op(24'h2468AC, 24'h002000, "R4 one bit mid");
      syn_op(24'h2468AC, 24'h800000, "R4 one bit top");
      syn_op(24'h55AA55, 24'h0007FF, "R4 eleven bits");

      syn_op(24'h55AA55, 24'h000003, "R5 two bits");
      syn_op(24'h55AA55, 24'h001FFF, "R5 thirteen bits");
      run_op(24'hFFFFFF, 24'h000000, 0, "R5 erased sector");
      run_op(24'h000000, 24'hFFFFFF, 0, "R5 inverted erased");
      run_op(24'hFFFFFF, 24'h000001, 0, "R5 near erased");

      run_op(24'h9ABCDE, from_form(to_form(24'h9ABCDE) ^ loc_syn(77, 3)), 1, "R8 busy poke fix");
      run_op(24'h111111, 24'h111111, 1, "R8 busy poke clean");

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule